// File: doc/BRIEF.md
# Trilinear Interpolation Pipeline

This block blends the eight corner values of a unit cube into one value at a fractional point inside the cube. Each evaluation arrives as one beat that carries all eight signed 24-bit corners together with three unsigned 12-bit fractions. The block blends the x pairs first, then the y pairs, then the z pair, so one blend is left at the end. Each blend step is computed as `a + f*(b-a)`, which needs only one multiplier per blend. Every product is truncated toward minus infinity. There is no rounding and no saturation.

The datapath is a straight pipeline of ten register stages and never stalls. It accepts one beat in every cycle after reset, and a result leaves ten cycles after its beat was taken. A valid bit and a batch-end flag travel alongside the data. A counter groups the accepted beats into runs of ten. It marks the result of every tenth beat, so a batch fed back to back finishes 19 cycles after its first beat, and the next batch can follow at once.

Top module: `tri_interp_top`

## Requirements
- R1: Corner k sits in `in_corners[24k+23:24k]`, with index k = x + 2y + 4z (bit 0 selects x). Corners are two's-complement signed. Each fraction is unsigned and stands for its value divided by 4096.
- R2: The result is lerp_z(lerp_y(lerp_x(...))). Each lerp step is `a + floor((b-a)*f/4096)`, which truncates toward minus infinity and never rounds.
- R3: A beat accepted at a clock edge shows its result with `out_valid` high exactly 10 cycles later. Back-to-back beats give back-to-back results.
- R4: `in_ready` is low while reset is asserted. It is high in every cycle after reset, so a beat can be taken in every cycle.
- R5: A cycle with `in_valid` low produces no result and does not advance the batch count.
- R6: `out_last` is high with the result of every tenth accepted beat. With back-to-back input, the last result of a batch appears 19 cycles after the batch's first beat, and the following batch continues the count with no gap.
- R7: Reset clears the whole pipeline and the batch count. Beats taken before reset never produce a result, and the count restarts at the first beat after reset.
- R8: Full-scale corners, such as -8388608 blended toward 8388607 with fraction 4095, give the exact truncated value. No intermediate value overflows, and the output is the low 24 bits of the final sum.
- R9: `out_last` is never high while `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Beat offered this cycle |
| in_ready | output | 1 | Block can take a beat |
| in_corners | input | 192 | Eight packed 24-bit corner values |
| in_fx | input | 12 | Fraction along x |
| in_fy | input | 12 | Fraction along y |
| in_fz | input | 12 | Fraction along z |
| out_valid | output | 1 | Result present |
| out_data | output | 24 | Interpolated value |
| out_last | output | 1 | Result closes a batch of ten |

## Verification
Two things can happen in the same cycle. The flag that closes one batch can leave the block while the beats of the next batch are still being accepted. The batch counter can also wrap on the same edge that takes a new beat. The bench runs two batches of ten beats with no gap between them. It then requires `out_last` on result 10 and result 20 only, each exactly ten cycles after its beat. A second run inserts bubbles between beats to show that idle cycles neither shift the flag nor produce output. A reset in the middle of a batch shows that the count restarts.

// File: rtl/tri_interp_pkg.sv
package tri_interp_pkg;

    localparam int SAMPLE_W_DEF  = 24;
    localparam int FRAC_W_DEF    = 12;
    localparam int CORNERS       = 8;
    localparam int BATCH_LEN_DEF = 10;
    localparam int LERP_STAGES   = 3;

    typedef struct packed {
        logic valid;
        logic last;
    } beat_tag_t;

endpackage

// File: rtl/tri_lerp_lane.sv
module tri_lerp_lane #(
    parameter int W  = 24,
    parameter int FW = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic signed [W-1:0] a_i,
    input  logic signed [W-1:0] b_i,
    input  logic [FW-1:0]       f_i,
    output logic signed [W-1:0] y_o
);

    localparam int PW = W + FW + 2;

    typedef struct packed {
        logic [W:0]    diff;
        logic [W-1:0]  a1;
        logic [FW-1:0] f1;
        logic [PW-1:0] prod;
        logic [W-1:0]  a2;
        logic [W-1:0]  y;
        logic [1:0]    fill;
    } lane_st_t;

    lane_st_t lane_d, lane_q;
    logic signed [PW-1:0]  shifted;
    logic signed [W+1:0]   sum_wide;

    always_comb begin
        lane_d      = lane_q;
        // stage 1: difference of the pair, operands carried along
        lane_d.diff = $signed({b_i[W-1], b_i}) - $signed({a_i[W-1], a_i});
        lane_d.a1   = a_i;
        lane_d.f1   = f_i;
        // stage 2: scale by the unsigned fraction
        lane_d.prod = $signed(lane_q.diff) * $signed({1'b0, lane_q.f1});
        lane_d.a2   = lane_q.a1;
        // stage 3: truncating shift and sum
        shifted     = $signed(lane_q.prod) >>> FW;
        sum_wide    = $signed({{2{lane_q.a2[W-1]}}, lane_q.a2}) + $signed(shifted[W+1:0]);
        lane_d.y    = sum_wide[W-1:0];
        if (lane_q.fill != 2'd3) begin
            lane_d.fill = lane_q.fill + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign y_o = $signed(lane_q.y);

    // R8: the wide sum never leaves the sample range
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_wide[W+1] == sum_wide[W]) && (sum_wide[W] == sum_wide[W-1]));

    // R2: a blend lies between its two operands taken three cycles earlier
    assert_blend_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_q.fill == 2'd3) |->
        (((y_o >= $past(a_i, 3)) && (y_o <= $past(b_i, 3))) ||
         ((y_o <= $past(a_i, 3)) && (y_o >= $past(b_i, 3)))));

endmodule

// File: rtl/tri_batch_seq.sv
module tri_batch_seq #(
    parameter int LEN = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take_i,
    output logic last_o
);

    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LEN_M1 = CW'(LEN - 1);

    typedef struct packed {
        logic [CW-1:0] idx;
    } seq_st_t;

    seq_st_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (take_i) begin
            seq_d.idx = (seq_q.idx == LEN_M1) ? '0 : seq_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign last_o = take_i && (seq_q.idx == LEN_M1);

    // R6: count wraps to zero after the closing beat
    assert_count_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && (seq_q.idx == LEN_M1)) |=> (seq_q.idx == '0));

    // R5: idle cycles leave the count untouched
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> $stable(seq_q.idx));

    // R6: count stays within the batch
    assert_count_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.idx <= LEN_M1);

endmodule

// File: rtl/tri_interp_top.sv
module tri_interp_top
    import tri_interp_pkg::*;
#(
    parameter int SAMPLE_W  = SAMPLE_W_DEF,
    parameter int FRAC_W    = FRAC_W_DEF,
    parameter int BATCH_LEN = BATCH_LEN_DEF
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    output logic                           in_ready,
    input  logic [CORNERS*SAMPLE_W-1:0]    in_corners,
    input  logic [FRAC_W-1:0]              in_fx,
    input  logic [FRAC_W-1:0]              in_fy,
    input  logic [FRAC_W-1:0]              in_fz,
    output logic                           out_valid,
    output logic [SAMPLE_W-1:0]            out_data,
    output logic                           out_last
);

    localparam int NX     = CORNERS / 2;
    localparam int NY     = NX / 2;
    localparam int FY_DLY = LERP_STAGES;
    localparam int FZ_DLY = 2 * LERP_STAGES;
    localparam int LAT    = 1 + 3 * LERP_STAGES;
    localparam int AGE_W  = $clog2(LAT + 1);
    localparam logic [AGE_W-1:0] LAT_AGE = AGE_W'(LAT);

    typedef struct packed {
        logic                               ready;
        logic [CORNERS*SAMPLE_W-1:0]        corners;
        logic [FRAC_W-1:0]                  fx;
        logic [FY_DLY:0][FRAC_W-1:0]        fy_pipe;
        logic [FZ_DLY:0][FRAC_W-1:0]        fz_pipe;
        beat_tag_t [LAT-1:0]                tags;
        logic [AGE_W-1:0]                   age;
    } top_st_t;

    top_st_t top_d, top_q;
    logic    take;
    logic    batch_last;

    logic signed [SAMPLE_W-1:0] x_res [NX];
    logic signed [SAMPLE_W-1:0] y_res [NY];
    logic signed [SAMPLE_W-1:0] z_res;

    assign take = in_valid && top_q.ready;

    tri_batch_seq #(.LEN(BATCH_LEN)) u_batch (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (take),
        .last_o (batch_last)
    );

    always_comb begin
        top_d            = top_q;
        top_d.ready      = 1'b1;
        top_d.corners    = in_corners;
        top_d.fx         = in_fx;
        top_d.fy_pipe[0] = in_fy;
        top_d.fz_pipe[0] = in_fz;
        for (int k = 1; k <= FY_DLY; k++) begin
            top_d.fy_pipe[k] = top_q.fy_pipe[k-1];
        end
        for (int k = 1; k <= FZ_DLY; k++) begin
            top_d.fz_pipe[k] = top_q.fz_pipe[k-1];
        end
        top_d.tags[0].valid = take;
        top_d.tags[0].last  = batch_last;
        for (int k = 1; k < LAT; k++) begin
            top_d.tags[k] = top_q.tags[k-1];
        end
        if (top_q.age != LAT_AGE) begin
            top_d.age = top_q.age + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    // blend along x: pairs of corners that differ in index bit 0
    for (genvar gx = 0; gx < NX; gx++) begin : g_x
        tri_lerp_lane #(.W(SAMPLE_W), .FW(FRAC_W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .a_i   (top_q.corners[(2*gx)*SAMPLE_W +: SAMPLE_W]),
            .b_i   (top_q.corners[(2*gx+1)*SAMPLE_W +: SAMPLE_W]),
            .f_i   (top_q.fx),
            .y_o   (x_res[gx])
        );
    end

    // blend along y
    for (genvar gy = 0; gy < NY; gy++) begin : g_y
        tri_lerp_lane #(.W(SAMPLE_W), .FW(FRAC_W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .a_i   (x_res[2*gy]),
            .b_i   (x_res[2*gy+1]),
            .f_i   (top_q.fy_pipe[FY_DLY]),
            .y_o   (y_res[gy])
        );
    end

    // blend along z
    tri_lerp_lane #(.W(SAMPLE_W), .FW(FRAC_W)) u_lane_z (
        .clk   (clk),
        .rst_n (rst_n),
        .a_i   (y_res[0]),
        .b_i   (y_res[1]),
        .f_i   (top_q.fz_pipe[FZ_DLY]),
        .y_o   (z_res)
    );

    assign in_ready  = top_q.ready;
    assign out_valid = top_q.tags[LAT-1].valid;
    assign out_last  = top_q.tags[LAT-1].last;
    assign out_data  = z_res;

    // R4: once ready, the block stays ready
    assert_ready_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> in_ready);

    // R3: every result follows its accepted beat by exactly LAT cycles
    assert_fixed_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (top_q.age == LAT_AGE) |-> (out_valid == $past(in_valid && in_ready, LAT)));

    // R9: the batch flag only rides on a valid result
    assert_last_has_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

endmodule

// File: tb/tri_interp_top_tb_top.sv
module tri_interp_top_tb_top;

    typedef struct packed {
        logic [0:7][23:0] c;
        logic [11:0]      fx;
        logic [11:0]      fy;
        logic [11:0]      fz;
        logic [23:0]      exp_v;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{'{24'd100, 24'd100, 24'd100, 24'd100, 24'd100, 24'd100, 24'd100, 24'd100},
          12'd1234, 12'd567, 12'd3000, 24'd100},
        '{'{24'd1000, 24'd1001, 24'd1002, 24'd1003, 24'd1004, 24'd1005, 24'd1006, 24'd1007},
          12'd0, 12'd0, 12'd0, 24'd1000},
        '{'{24'd0, 24'd4096, 24'd8192, 24'd12288, 24'd16384, 24'd20480, 24'd24576, 24'd28672},
          12'd2048, 12'd0, 12'd0, 24'd2048},
        '{'{24'd0, 24'd4096, 24'd8192, 24'd12288, 24'd16384, 24'd20480, 24'd24576, 24'd28672},
          12'd0, 12'd2048, 12'd0, 24'd4096},
        '{'{24'd0, 24'd4096, 24'd8192, 24'd12288, 24'd16384, 24'd20480, 24'd24576, 24'd28672},
          12'd0, 12'd0, 12'd2048, 24'd8192},
        '{'{24'd0, 24'd4096, 24'd8192, 24'd12288, 24'd16384, 24'd20480, 24'd24576, 24'd28672},
          12'd1024, 12'd1024, 12'd1024, 24'd7168},
        '{'{24'd0, 24'hFFFFFF, 24'd0, 24'd0, 24'd0, 24'd0, 24'd0, 24'd0},
          12'd2048, 12'd0, 12'd0, 24'hFFFFFF},
        '{'{24'd0, 24'd1, 24'd0, 24'd0, 24'd0, 24'd0, 24'd0, 24'd0},
          12'd2048, 12'd0, 12'd0, 24'd0},
        '{'{24'h800000, 24'h7FFFFF, 24'd0, 24'd0, 24'd0, 24'd0, 24'd0, 24'd0},
          12'd4095, 12'd0, 12'd0, 24'h7FEFFF},
        '{'{24'd0, 24'd4096, 24'd0, 24'd0, 24'd0, 24'd0, 24'd0, 24'd0},
          12'd4095, 12'd0, 12'd0, 24'd4095}
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         in_ready;
    logic [191:0] in_corners;
    logic [11:0]  in_fx, in_fy, in_fz;
    logic         out_valid;
    logic [23:0]  out_data;
    logic         out_last;

    always #5ns clk = ~clk;

    tri_interp_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_corners (in_corners),
        .in_fx      (in_fx),
        .in_fy      (in_fy),
        .in_fz      (in_fz),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_last   (out_last)
    );

    int          total = 0;
    int          fails = 0;
    int          stepno = 0;
    int          nrec = 0;
    int          stray = 0;
    logic        done = 1'b0;
    logic [23:0] rec_d [64];
    logic        rec_l [64];
    int          rec_s [64];
    int          bs [10];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        total++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (out_last === 1'b1 && out_valid !== 1'b1) stray++;
        if (out_valid === 1'b1 && nrec < 64) begin
            rec_d[nrec] = out_data;
            rec_l[nrec] = out_last;
            rec_s[nrec] = stepno + 1;
            nrec++;
        end
        stepno++;
    endtask

    task automatic drive(input vec_t v);
        in_valid = 1'b1;
        for (int k = 0; k < 8; k++) in_corners[k*24 +: 24] = v.c[k];
        in_fx = v.fx;
        in_fy = v.fy;
        in_fz = v.fz;
    endtask

    task automatic idle();
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int base;
        rst_n      = 1'b0;
        in_valid   = 1'b0;
        in_corners = '0;
        in_fx      = '0;
        in_fy      = '0;
        in_fz      = '0;

        // reset state (R4, R7)
        repeat (3) step();
        chk("R7 reset out_valid", {31'd0, out_valid}, 32'd0);
        chk("R7 reset out_last", {31'd0, out_last}, 32'd0);
        chk("R4 reset in_ready", {31'd0, in_ready}, 32'd0);
        rst_n = 1'b1;
        step();
        chk("R4 ready after reset", {31'd0, in_ready}, 32'd1);
        step();

        // two batches back to back, the table walked twice (R1, R2, R3, R6, R8)
        nrec = 0;
        base = stepno;
        for (int i = 0; i < 20; i++) begin
            drive(VEC[i % 10]);
            step();
            chk("R4 ready under load", {31'd0, in_ready}, 32'd1);
        end
        idle();
        repeat (14) step();
        chk("R6 result count", nrec, 32'd20);
        for (int k = 0; k < 20; k++) begin
            chk(((k % 10) == 8) ? "R8 full-scale value" : "R1/R2 value",
                {8'd0, rec_d[k]}, {8'd0, VEC[k % 10].exp_v});
            chk("R3 latency", rec_s[k], base + k + 10);
            chk("R6 batch flag", {31'd0, rec_l[k]}, {31'd0, ((k % 10) == 9)});
        end
        chk("R6 first batch ends 19 cycles after first beat", rec_s[9] - (base + 0), 32'd19);

        // beats with bubbles between them (R3, R5)
        nrec = 0;
        for (int i = 0; i < 10; i++) begin
            drive(VEC[i]);
            bs[i] = stepno;
            step();
            idle();
            for (int g = 0; g < (i % 3); g++) step();
        end
        idle();
        repeat (14) step();
        chk("R5 no output for idle cycles", nrec, 32'd10);
        for (int k = 0; k < 10; k++) begin
            chk("R3 latency with gaps", rec_s[k], bs[k] + 10);
            chk("R5 flag unaffected by gaps", {31'd0, rec_l[k]}, {31'd0, (k == 9)});
            chk("R2 value with gaps", {8'd0, rec_d[k]}, {8'd0, VEC[k].exp_v});
        end

        // reset in the middle of a batch (R7)
        nrec = 0;
        for (int i = 0; i < 5; i++) begin
            drive(VEC[i]);
            step();
        end
        idle();
        rst_n = 1'b0;
        step();
        chk("R7 out_valid cleared", {31'd0, out_valid}, 32'd0);
        step();
        rst_n = 1'b1;
        repeat (14) step();
        chk("R7 no stale results", nrec, 32'd0);
        base = stepno;
        for (int i = 0; i < 10; i++) begin
            drive(VEC[i]);
            step();
        end
        idle();
        repeat (14) step();
        chk("R7 results after reset", nrec, 32'd10);
        for (int k = 0; k < 10; k++) begin
            chk("R7 count restarted", {31'd0, rec_l[k]}, {31'd0, (k == 9)});
            chk("R3 latency after reset", rec_s[k], base + k + 10);
        end

        chk("R9 no flag without valid", stray, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule